// File: doc/BRIEF.md
# Two-Requester Processor Bus Arbiter

This block decides which of two processors, CPU0 or CPU1, owns a shared processor bus. Each processor raises its own request line. The arbiter answers on one grant line per processor. A bus-busy input marks a transfer in flight, and the grant is frozen while it is high. The grant output is registered. It always moves through a cycle with no owner before it passes from one processor to the other.

A small control register selects the policy at run time. One bit chooses fixed priority, where CPU0 wins, or alternating priority. A 2-bit field chooses what happens while nobody requests: release the bus, park on the last owner, park on CPU0, or park on CPU1. A read-only status bit shows whether this arbiter is active. That state is taken from a strap pin during reset. When the arbiter is inactive, an external arbiter is expected to take over and both grants stay low.

Top module: `cpu_bus_arbiter`

## Requirements
- R1: The level of `arb_en_strap_i` while `rst_ni` is low becomes the enable state and reads back in `cfg_rdata_o[3]`. While the enable state is 0, both grant bits stay 0 whatever the requests and configuration.
- R2: After reset, `gnt_o` is 2'b00, `cfg_rdata_o[2:0]` is 3'b000 (fixed priority, no parking), and the last-owner record points at CPU0.
- R3: A write with `cfg_we_i` high stores `cfg_wdata_i[2]` as the rotate bit and `cfg_wdata_i[1:0]` as the park code. These read back at the same positions of `cfg_rdata_o`, and the new settings take effect from the following cycle.
- R4: With the rotate bit at 0, both requesting and no owner, CPU0 (`gnt_o` = 2'b01) is granted.
- R5: With the rotate bit at 1, both requesting and no owner, the grant goes to the CPU that is not the last owner.
- R6: A single requester is granted regardless of mode (bit 0 = CPU0, bit 1 = CPU1).
- R7: Park code 2'b00: with no request, an existing grant is removed and no grant is issued.
- R8: Park code 2'b01: with no request, the grant goes to or stays on the last owner.
- R9: Park code 2'b10 parks on CPU0 and code 2'b11 parks on CPU1 when nobody requests.
- R10: While `bus_busy_i` is high, `gnt_o` in the next cycle equals its current value.
- R11: At most one grant bit is high. Moving ownership from one CPU to the other always passes through a cycle with `gnt_o` = 2'b00.
- R12: `gnt_o` is registered. A decision taken from inputs sampled at a clock edge appears just after that edge, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arb_en_strap_i | input | 1 | Enable strap, sampled during reset |
| req_i | input | 2 | Bus requests, bit n from CPUn |
| bus_busy_i | input | 1 | High while a transfer is in progress |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 3 | {rotate, park[1:0]} write data |
| cfg_rdata_o | output | 4 | {enabled, rotate, park[1:0]} read data |
| gnt_o | output | 2 | Grants, bit n to CPUn, at most one high |

## Verification
Every combination of rotate bit and park code is driven through all ordered pairs of {request pattern, busy} input vectors. Each pair is compared against an arithmetic restatement of the rules. These pairs separate holding under busy from handover, single-requester wins from ties, and parking from release. They also expose the mandatory idle cycle on every handover. Directed sequences then fix the tie winner in both priority modes and the last-owner record that alternating mode depends on. A second reset with the strap low shows that no input pattern produces a grant.

// File: rtl/cpu_arb_pkg.sv
package cpu_arb_pkg;

  localparam int unsigned NUM_CPU = 2;
  localparam int unsigned PARK_W  = 2;

  typedef enum logic [PARK_W-1:0] {
    PARK_NONE = 2'b00,
    PARK_LAST = 2'b01,
    PARK_CPU0 = 2'b10,
    PARK_CPU1 = 2'b11
  } park_mode_e;

  typedef struct packed {
    logic       rotate;
    park_mode_e park;
  } arb_cfg_t;

  localparam int unsigned CFG_W = $bits(arb_cfg_t);

  // Owner index of the winning requester (req must be non-zero).
  function automatic logic arb_pick(input logic [NUM_CPU-1:0] req,
                                    input logic rotate,
                                    input logic last);
    if (req == 2'b11) return rotate ? ~last : 1'b0;
    return req[1] & ~req[0];
  endfunction

  // Parking target when idle: {valid, owner}.
  function automatic logic [1:0] park_target(input park_mode_e park,
                                             input logic last);
    case (park)
      PARK_LAST: return {1'b1, last};
      PARK_CPU0: return 2'b10;
      PARK_CPU1: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic [NUM_CPU-1:0] owner_to_gnt(input logic owner);
    return owner ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/cpu_arb_cfg.sv
module cpu_arb_cfg
  import cpu_arb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  arb_cfg_t wdata_i,
  output arb_cfg_t cfg_o
);

  arb_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{rotate: 1'b0, park: PARK_NONE};
    end else if (we_i) begin
      cfg_q <= wdata_i;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/cpu_arb_select.sv
module cpu_arb_select
  import cpu_arb_pkg::*;
(
  input  logic [NUM_CPU-1:0] req_i,
  input  arb_cfg_t           cfg_i,
  input  logic               last_i,
  output logic               tgt_valid_o,
  output logic               tgt_owner_o
);

  logic [1:0] park_tv;

  assign park_tv = park_target(cfg_i.park, last_i);

  always_comb begin
    if (|req_i) begin
      tgt_valid_o = 1'b1;
      tgt_owner_o = arb_pick(req_i, cfg_i.rotate, last_i);
    end else begin
      tgt_valid_o = park_tv[1];
      tgt_owner_o = park_tv[0];
    end
  end

endmodule

// File: rtl/cpu_arb_grant.sv
module cpu_arb_grant
  import cpu_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               busy_i,
  input  logic               tgt_valid_i,
  input  logic               tgt_owner_i,
  output logic [NUM_CPU-1:0] gnt_o,
  output logic               last_o,
  output logic               switch_gap_o
);

  logic [NUM_CPU-1:0] gnt_q, gnt_d, tgt_gnt;
  logic               last_q, last_d;

  assign tgt_gnt = owner_to_gnt(tgt_owner_i);

  assign switch_gap_o = en_i && !busy_i && tgt_valid_i &&
                        (gnt_q != '0) && (gnt_q != tgt_gnt);

  always_comb begin
    gnt_d = gnt_q;
    if (!en_i) begin
      gnt_d = '0;
    end else if (!busy_i) begin
      if (!tgt_valid_i)          gnt_d = '0;
      else if (gnt_q == '0)      gnt_d = tgt_gnt;
      else if (gnt_q != tgt_gnt) gnt_d = '0;
    end
    last_d = (gnt_d != '0) ? gnt_d[1] : last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt_o  = gnt_q;
  assign last_o = last_q;

endmodule

// File: rtl/cpu_bus_arbiter.sv
module cpu_bus_arbiter
  import cpu_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arb_en_strap_i,
  input  logic [NUM_CPU-1:0] req_i,
  input  logic               bus_busy_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W:0]     cfg_rdata_o,
  output logic [NUM_CPU-1:0] gnt_o
);

  arb_cfg_t cfg;
  logic     en_q;
  logic     last_owner;
  logic     tgt_valid;
  logic     tgt_owner;
  logic     switch_gap;

  // Enable state latched from the strap while reset is held.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= arb_en_strap_i;
    else         en_q <= en_q;
  end

  cpu_arb_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (arb_cfg_t'(cfg_wdata_i)),
    .cfg_o   (cfg)
  );

  cpu_arb_select u_sel (
    .req_i       (req_i),
    .cfg_i       (cfg),
    .last_i      (last_owner),
    .tgt_valid_o (tgt_valid),
    .tgt_owner_o (tgt_owner)
  );

  cpu_arb_grant u_gnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .busy_i       (bus_busy_i),
    .tgt_valid_i  (tgt_valid),
    .tgt_owner_i  (tgt_owner),
    .gnt_o        (gnt_o),
    .last_o       (last_owner),
    .switch_gap_o (switch_gap)
  );

  assign cfg_rdata_o = {en_q, cfg};

endmodule

// File: rtl/cpu_arb_chk.sv
module cpu_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_i,
  input logic       bus_busy_i,
  input logic [3:0] cfg_rdata_o,
  input logic [1:0] gnt_o,
  input logic       last_owner,
  input logic       tgt_valid,
  input logic       tgt_owner,
  input logic       switch_gap
);

  logic live;
  assign live = cfg_rdata_o[3] && !bus_busy_i;

  // R1
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[3] |-> gnt_o == 2'b00);

  // R11
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R11
  gap_cpu0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[0] |=> !gnt_o[1]);

  // R11
  gap_cpu1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[1] |=> !gnt_o[0]);

  // R11
  switch_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_gap |=> gnt_o == 2'b00);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i |=> $stable(gnt_o));

  // R4
  fixed_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && req_i == 2'b11 && !cfg_rdata_o[2] && gnt_o == 2'b00)
      |=> gnt_o == 2'b01);

  // R5
  rotate_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && req_i == 2'b11 && cfg_rdata_o[2] && gnt_o == 2'b00)
      |=> gnt_o == ($past(last_owner) ? 2'b01 : 2'b10));

  // R7
  park_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && req_i == 2'b00 && cfg_rdata_o[1:0] == 2'b00) |=> gnt_o == 2'b00);

  // R12
  target_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && tgt_valid && gnt_o == 2'b00)
      |=> gnt_o == ($past(tgt_owner) ? 2'b10 : 2'b01));

endmodule

bind cpu_bus_arbiter cpu_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .bus_busy_i  (bus_busy_i),
  .cfg_rdata_o (cfg_rdata_o),
  .gnt_o       (gnt_o),
  .last_owner  (last_owner),
  .tgt_valid   (tgt_valid),
  .tgt_owner   (tgt_owner),
  .switch_gap  (switch_gap)
);

// File: tb/cpu_bus_arbiter_bench.sv
module cpu_bus_arbiter_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arb_en_strap_i = 1'b1;
  logic [1:0] req_i = 2'b00;
  logic       bus_busy_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_wdata_i = 3'b000;
  logic [3:0] cfg_rdata_o;
  logic [1:0] gnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [1:0] m_gnt;
  logic       m_last, m_rot, m_en;
  logic [1:0] m_park;

  always #4 clk_i = ~clk_i;

  cpu_bus_arbiter u_cpu_bus_arbiter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arb_en_strap_i (arb_en_strap_i),
    .req_i          (req_i),
    .bus_busy_i     (bus_busy_i),
    .cfg_we_i       (cfg_we_i),
    .cfg_wdata_i    (cfg_wdata_i),
    .cfg_rdata_o    (cfg_rdata_o),
    .gnt_o          (gnt_o)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Rules restated as integer arithmetic: want = -1 means nobody.
  function automatic logic [1:0] ref_next(input logic [1:0] r, input logic b);
    int want;
    if (!m_en) return 2'b00;
    if (b) return m_gnt;
    if (r == 2'd3)      want = m_rot ? 1 - int'(m_last) : 0;
    else if (r == 2'd1) want = 0;
    else if (r == 2'd2) want = 1;
    else begin
      case (m_park)
        2'd1:    want = int'(m_last);
        2'd2:    want = 0;
        2'd3:    want = 1;
        default: want = -1;
      endcase
    end
    if (want < 0) return 2'b00;
    if (m_gnt == 2'b00) return 2'(1 << want);
    return (m_gnt == 2'(1 << want)) ? m_gnt : 2'b00;
  endfunction

  task automatic model_step(input logic [1:0] r, input logic b);
    m_gnt = ref_next(r, b);
    if (m_gnt != 2'b00) m_last = m_gnt[1];
  endtask

  task automatic cyc(input logic [1:0] r, input logic b);
    req_i = r;
    bus_busy_i = b;
    @(posedge clk_i);
    model_step(r, b);
    @(negedge clk_i);
  endtask

  task automatic wcfg(input logic rot, input logic [1:0] park);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {rot, park};
    req_i = 2'b00;
    bus_busy_i = 1'b0;
    @(posedge clk_i);
    model_step(2'b00, 1'b0);
    m_rot = rot;
    m_park = park;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    arb_en_strap_i = strap;
    req_i = 2'b00;
    bus_busy_i = 1'b0;
    cfg_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_gnt = 2'b00; m_last = 1'b0; m_rot = 1'b0; m_park = 2'b00; m_en = strap;
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R2 reset state, R1 enable status
    chk("R2 gnt", {2'b00, gnt_o}, 4'b0000);
    chk("R2 rdata", cfg_rdata_o, 4'b1000);
    chk("R1 enabled", {3'b000, cfg_rdata_o[3]}, 4'b0001);

    // R12: request seen before the edge leaves the grant untouched
    req_i = 2'b11;
    #1;
    chk("R12 before edge", {2'b00, gnt_o}, 4'b0000);

    cyc(2'b11, 1'b0); chk("R4 fixed tie", {2'b00, gnt_o}, 4'b0001);
    cyc(2'b11, 1'b1); chk("R10 busy hold", {2'b00, gnt_o}, 4'b0001);
    cyc(2'b10, 1'b1); chk("R10 busy blocks switch", {2'b00, gnt_o}, 4'b0001);
    cyc(2'b10, 1'b0); chk("R11 gap", {2'b00, gnt_o}, 4'b0000);
    cyc(2'b10, 1'b0); chk("R6 single CPU1", {2'b00, gnt_o}, 4'b0010);
    cyc(2'b00, 1'b0); chk("R7 no park", {2'b00, gnt_o}, 4'b0000);

    wcfg(1'b1, 2'b00);
    chk("R3 readback", cfg_rdata_o, 4'b1100);
    cyc(2'b11, 1'b0); chk("R5 tie after CPU1", {2'b00, gnt_o}, 4'b0001);
    cyc(2'b11, 1'b0); chk("R11 rotate gap", {2'b00, gnt_o}, 4'b0000);
    cyc(2'b11, 1'b0); chk("R5 tie after CPU0", {2'b00, gnt_o}, 4'b0010);

    wcfg(1'b1, 2'b01);
    chk("R3 readback last", cfg_rdata_o, 4'b1101);
    cyc(2'b00, 1'b0); chk("R8 park last", {2'b00, gnt_o}, 4'b0010);

    wcfg(1'b0, 2'b10);
    chk("R8 park last holds", {2'b00, gnt_o}, 4'b0010);
    cyc(2'b00, 1'b0); chk("R11 park move gap", {2'b00, gnt_o}, 4'b0000);
    cyc(2'b00, 1'b0); chk("R9 park CPU0", {2'b00, gnt_o}, 4'b0001);

    wcfg(1'b0, 2'b11);
    cyc(2'b00, 1'b0);
    cyc(2'b00, 1'b0); chk("R9 park CPU1", {2'b00, gnt_o}, 4'b0010);
    cyc(2'b01, 1'b0);
    cyc(2'b01, 1'b0); chk("R6 single CPU0", {2'b00, gnt_o}, 4'b0001);

    // Sweep: every config, every ordered pair of {req,busy} vectors.
    for (int c = 0; c < 8; c++) begin
      wcfg(c[2], c[1:0]);
      chk("R3 sweep readback", cfg_rdata_o, {1'b1, 3'(c)});
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          cyc(a[1:0], a[2]);
          chk("R12 sweep first", {2'b00, gnt_o}, {2'b00, m_gnt});
          cyc(b[1:0], b[2]);
          chk("R12 sweep second", {2'b00, gnt_o}, {2'b00, m_gnt});
          chk("R11 onehot", {3'b000, ($countones(gnt_o) <= 1)}, 4'b0001);
        end
      end
    end

    // R1: strap low disables every grant
    do_reset(1'b0);
    chk("R1 disabled status", cfg_rdata_o, 4'b0000);
    for (int c = 0; c < 8; c++) begin
      wcfg(c[2], c[1:0]);
      for (int a = 0; a < 8; a++) begin
        cyc(a[1:0], a[2]);
        chk("R1 no grant", {2'b00, gnt_o}, 4'b0000);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule